// File: doc/BRIEF.md
# Dual-Slope / Single-Slope PWM Timer Channel

This block is an 8-bit timer with a single output-compare channel that drives one PWM pin. A prescaled tick advances the counter. A mode select chooses between two ramps. The single-slope ramp counts up and wraps, which gives an edge-aligned waveform with a 256-tick period. The dual-slope ramp counts up to the top and back down, which gives a center-aligned waveform with a 510-tick period.

Software-style writes to the compare value land in a buffer first. The active compare value is refreshed only when the counter sits at its maximum. A 2-bit output-mode field takes effect at once and is not buffered. It selects whether the pin is driven by a plain port value or by the internal waveform state, and it selects which edge the compare match produces.

The two extreme compare values behave differently in the two ramps:
- In single-slope mode, a compare value of 0 still gives a one-tick spike in each period. A compare value of 255 gives a constant level.
- In dual-slope mode, 0 gives a clean 0% duty and 255 gives a clean 100% duty.

Top module: `pwm_channel`

## Requirements
- R1: Reset state. After synchronous reset the counter is 0, both compare registers are 0, the waveform state is 0 and the overflow pulse is low. With output mode 00 and single-slope mode selected, the first overflow is seen 256 ticks after reset is released.
- R2: Single-slope counter. In single-slope mode (ramp_sel=0) the counter steps 0..255 and wraps to 0. The overflow pulse is high for one clock after each wrap, which gives exactly 4 pulses in 1024 ticks.
- R3: Single-slope non-inverting output (mode 10). The waveform state is set on the tick that wraps the counter and cleared on the tick where the count equals the active compare value v. Each 256-tick period therefore holds v+1 high ticks. For v=0 this is a one-tick spike.
- R4: Single-slope extreme value 255. When set and clear fall on the same tick, set wins. Mode 10 therefore gives a constant high pin and mode 11 a constant low pin.
- R5: Inverting output (mode 11). Mode 11 swaps the set and clear actions of mode 10 in both ramps. In single-slope mode the pin is high for 255-v ticks per period; in dual-slope mode it is high for 510-2v ticks.
- R6: Dual-slope counter. With ramp_sel=1 the counter steps 0..255..0, so a period is 510 ticks. The overflow pulse follows each tick taken at count 0, which gives exactly 2 pulses in 1020 ticks.
- R7: Dual-slope extreme values. In mode 10, v=0 gives a pin that is always low and v=255 gives a pin that is always high, with no spike.
- R8: Dual-slope non-inverting output (mode 10). A match while counting up clears the state and a match while counting down sets it. The pin is therefore high for 2v ticks per 510-tick period.
- R9: Buffered compare. A write reaches the active compare value only on a tick taken at count 255. A write made in the same clock as that tick is used one period later.
- R10: Output-mode field. Mode 00 makes the pin follow port_val in the same cycle. Any non-zero mode makes the pin follow the internal waveform state in the same cycle. Modes 00 and 01 leave the waveform state unchanged.
- R11: Tick gating. Without tick_en the counter, the compare load, the waveform state and the overflow pulse do not change. With a tick on every second clock, the duty counted in clocks doubles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Prescaled count enable |
| ramp_sel | input | 1 | 0 = single-slope, 1 = dual-slope |
| out_mode | input | 2 | 00 port, 01 hold, 10 non-inverting, 11 inverting |
| cmp_wr | input | 1 | Compare buffer write strobe |
| cmp_wdata | input | 8 | Compare value to buffer |
| port_val | input | 1 | Pin level when output mode is 00 |
| pwm_pin | output | 1 | Pin level |
| ovf | output | 1 | One-clock overflow pulse |

## Verification
Two coincidences matter here. The first is a compare write landing on the same tick as the buffer load at count 255. The bench provokes it by writing exactly on the clock where the counter is at 255. It then expects the next period to keep the old duty and the one after it to show the new duty. The second is the set-at-wrap and the clear-on-match falling on the same tick when the compare value is 255. This is judged by counting high samples over a full period and expecting all or none of them, depending on polarity.

// File: rtl/pwm_pkg.sv
// Shared encodings for the PWM timer channel.
package pwm_pkg;
    // Output-mode field: source of the pin and action taken on a match.
    typedef enum logic [1:0] {
        OUT_PORT   = 2'b00,
        OUT_HOLD   = 2'b01,
        OUT_NONINV = 2'b10,
        OUT_INV    = 2'b11
    } out_mode_e;
endpackage

// File: rtl/pwm_counter.sv
// Timer counter for the PWM channel.
// Single-slope: counts 0..MAX and wraps. Dual-slope: counts 0..MAX..0.
// Assumes tick is a one-clock enable; nothing moves without it.
module pwm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         dual_slope,
    output logic [W-1:0] cnt,
    output logic         at_max,
    output logic         up_phase,
    output logic         ovf_o
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] cnt_q;
    logic         dir_up_q;
    logic         ovf_q;

    // Advance the count, track direction and raise the overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            dir_up_q <= 1'b1;
            ovf_q    <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (tick) begin
                if (dual_slope) begin
                    ovf_q <= (cnt_q == '0);
                    if (cnt_q == MAXV) begin
                        cnt_q    <= MAXV - ONE;
                        dir_up_q <= 1'b0;
                    end else if (cnt_q == '0) begin
                        cnt_q    <= ONE;
                        dir_up_q <= 1'b1;
                    end else begin
                        cnt_q <= dir_up_q ? cnt_q + ONE : cnt_q - ONE;
                    end
                end else begin
                    ovf_q    <= (cnt_q == MAXV);
                    cnt_q    <= cnt_q + ONE;
                    dir_up_q <= 1'b1;
                end
            end
        end
    end

    // Expose the count and the slope the current count belongs to.
    always_comb begin
        cnt      = cnt_q;
        at_max   = (cnt_q == MAXV);
        up_phase = (cnt_q == '0) || (dir_up_q && (cnt_q != MAXV));
        ovf_o    = ovf_q;
    end

    a_r2_fast_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dual_slope && cnt_q == MAXV) |=> (cnt_q == '0 && ovf_q));
    a_r6_pc_turn_top: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && dual_slope && cnt_q == MAXV) |=> (cnt_q == MAXV - ONE && !up_phase));
    a_r6_pc_turn_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && dual_slope && cnt_q == '0) |=> (cnt_q == ONE && up_phase && ovf_q));
    a_r11_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt_q) && !ovf_q));
endmodule

// File: rtl/pwm_compare.sv
// Double-buffered compare register and match detector.
// Writes land in a buffer; the active value is refreshed on a tick at MAX.
module pwm_compare #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         at_max,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cnt,
    output logic         match
);
    logic [W-1:0] buf_q;
    logic [W-1:0] act_q;

    // Capture writes in the buffer and load the active value at MAX.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            if (wr)
                buf_q <= wdata;
            if (tick && at_max)
                act_q <= buf_q;
        end
    end

    // Compare the running count against the active value.
    always_comb match = (cnt == act_q);

    a_r9_load_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && at_max) |=> $stable(act_q));
endmodule

// File: rtl/pwm_wavegen.sv
// Waveform state and pin-source selection.
// The output mode is used unbuffered: it picks the match action on the next
// tick and the pin source in the same cycle.
module pwm_wavegen
    import pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      dual_slope,
    input  logic      at_max,
    input  logic      up_phase,
    input  logic      match,
    input  out_mode_e mode,
    input  logic      port_val,
    output logic      pin
);
    logic oc_q;
    logic inv;

    always_comb inv = (mode == OUT_INV);

    // Update the waveform state on ticks when a driving mode is selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc_q <= 1'b0;
        end else if (tick && (mode == OUT_NONINV || mode == OUT_INV)) begin
            if (!dual_slope) begin
                if (at_max)
                    oc_q <= ~inv;
                else if (match)
                    oc_q <= inv;
            end else if (match) begin
                oc_q <= up_phase ? inv : ~inv;
            end
        end
    end

    // Route either the port value or the waveform state to the pin.
    always_comb pin = (mode == OUT_PORT) ? port_val : oc_q;

    a_r4_fast_max_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dual_slope && at_max && mode == OUT_NONINV) |=> oc_q);
    a_r5_fast_max_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dual_slope && at_max && mode == OUT_INV) |=> !oc_q);
    a_r7_pc_bottom_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && dual_slope && match && up_phase && mode == OUT_NONINV) |=> !oc_q);
    a_r8_pc_down_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && dual_slope && match && !up_phase && mode == OUT_NONINV) |=> oc_q);
    a_r10_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OUT_PORT || mode == OUT_HOLD) |=> $stable(oc_q));
    a_r10_hold_to_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OUT_HOLD) |-> (pin == oc_q));
endmodule

// File: rtl/pwm_channel.sv
// PWM timer channel top: counter, buffered compare and waveform generator.
// Assumes tick_en comes from an external prescaler, one clock wide.
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             ramp_sel,
    input  logic [1:0]       out_mode,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             port_val,
    output logic             pwm_pin,
    output logic             ovf
);
    logic [CNT_W-1:0] cnt;
    logic             at_max;
    logic             up_phase;
    logic             match;
    out_mode_e        mode;

    // Cast the raw mode field to its enumerated form.
    always_comb mode = out_mode_e'(out_mode);

    pwm_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .dual_slope(ramp_sel),
        .cnt(cnt), .at_max(at_max), .up_phase(up_phase), .ovf_o(ovf)
    );

    pwm_compare #(.W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .at_max(at_max),
        .wr(cmp_wr), .wdata(cmp_wdata), .cnt(cnt), .match(match)
    );

    pwm_wavegen u_wave (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .dual_slope(ramp_sel),
        .at_max(at_max), .up_phase(up_phase), .match(match), .mode(mode),
        .port_val(port_val), .pin(pwm_pin)
    );

    a_r1_quiet_reset: assert property (@(posedge clk)
        !rst_n |=> (!ovf && cnt == '0));
endmodule

// File: tb/test_pwm_channel.sv
module test_pwm_channel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       ramp_sel = 1'b0;
    logic [1:0] out_mode = 2'b00;
    logic       cmp_wr = 1'b0;
    logic [7:0] cmp_wdata = 8'd0;
    logic       port_val = 1'b1;
    logic       pwm_pin;
    logic       ovf;

    int tick_sel = 0; // 0 off, 1 every clock, 2 every second clock
    int checks = 0;
    int fails = 0;
    int act_v;
    bit done = 1'b0;

    typedef struct {
        string req;
        int    exp;
    } item_t;
    item_t q[$];
    event  res_ev;

    always #5 clk = ~clk;

    pwm_channel i_pwm_channel (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ramp_sel(ramp_sel),
        .out_mode(out_mode), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .port_val(port_val), .pwm_pin(pwm_pin), .ovf(ovf)
    );

    // Tick pattern generator, changed away from the active edge.
    always @(negedge clk) begin
        if (tick_sel == 2)      tick_en <= ~tick_en;
        else if (tick_sel == 1) tick_en <= 1'b1;
        else                    tick_en <= 1'b0;
    end

    // Monitor: pop expected items and compare with produced results.
    always @(res_ev) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (act_v != it.exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", it.req, act_v, it.exp);
        end
    end

    task automatic expect_val(input string r, input int e);
        item_t it;
        it.req = r;
        it.exp = e;
        q.push_back(it);
    endtask

    task automatic produce(input int a);
        act_v = a;
        ->res_ev;
        #1;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic high_count(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_pin) c++;
        end
    endtask

    task automatic ovf_count(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ovf) c++;
        end
    endtask

    task automatic wait_ovf();
        do @(negedge clk); while (!ovf);
    endtask

    task automatic set_cfg(input logic pc, input logic [1:0] om, input int v);
        @(negedge clk);
        ramp_sel  = pc;
        out_mode  = om;
        cmp_wr    = 1'b1;
        cmp_wdata = 8'(v);
        @(negedge clk);
        cmp_wr = 1'b0;
    endtask

    task automatic duty_check(input string r, input logic pc, input logic [1:0] om,
                              input int v, input int e);
        int c;
        set_cfg(pc, om, v);
        wait_n(pc ? 1100 : 600);
        expect_val(r, e);
        high_count(pc ? 510 : 256, c);
        produce(c);
    endtask

    initial begin
        int c;
        // R1: reset state, pin follows the port value with mode 00
        wait_n(3);
        expect_val("R1 pin during reset", 1);
        produce(int'(pwm_pin));
        expect_val("R1 ovf during reset", 0);
        produce(int'(ovf));
        @(negedge clk);
        port_val = 1'b0;
        rst_n    = 1'b1;
        tick_sel = 1;
        tick_en  = 1'b1;
        c = 0;
        do begin
            @(negedge clk);
            c++;
        end while (!ovf && c < 1000);
        expect_val("R1 first overflow after reset", 256);
        produce(c);

        // R2: single-slope overflow rate
        expect_val("R2 overflow pulses in 1024", 4);
        ovf_count(1024, c);
        produce(c);

        // R3/R4/R5: single-slope duty
        duty_check("R3 fast v=100", 1'b0, 2'b10, 100, 101);
        duty_check("R3 fast v=0 spike", 1'b0, 2'b10, 0, 1);
        duty_check("R4 fast v=255 noninv", 1'b0, 2'b10, 255, 256);
        duty_check("R5 fast inv v=100", 1'b0, 2'b11, 100, 155);
        duty_check("R4 fast v=255 inv", 1'b0, 2'b11, 255, 0);

        // R6: dual-slope overflow rate
        set_cfg(1'b1, 2'b10, 0);
        wait_n(600);
        expect_val("R6 pc overflow pulses in 1020", 2);
        ovf_count(1020, c);
        produce(c);

        // R7/R8/R5: dual-slope duty
        duty_check("R8 pc v=100", 1'b1, 2'b10, 100, 200);
        duty_check("R7 pc v=0", 1'b1, 2'b10, 0, 0);
        duty_check("R7 pc v=255", 1'b1, 2'b10, 255, 510);
        duty_check("R5 pc inv v=100", 1'b1, 2'b11, 100, 310);
        duty_check("R8 pc v=1", 1'b1, 2'b10, 1, 2);

        // R9: write in mid-period only applies after the next MAX tick
        duty_check("R9 fast setup v=100", 1'b0, 2'b10, 100, 101);
        wait_ovf();
        cmp_wr = 1'b1;
        cmp_wdata = 8'd200;
        @(negedge clk);
        cmp_wr = 1'b0;
        // first sample above was count 1; 255 more complete the period
        c = pwm_pin ? 1 : 0;
        begin
            int c2;
            high_count(255, c2);
            c += c2;
        end
        expect_val("R9 old value held for period", 101);
        produce(c);
        expect_val("R9 new value next period", 201);
        high_count(256, c);
        produce(c);

        // R9: write coinciding with the MAX-tick load is deferred one period
        wait_ovf();
        wait_n(255);
        cmp_wr = 1'b1;
        cmp_wdata = 8'd50;
        expect_val("R9 coincident write not yet loaded", 201);
        high_count(1, c);
        cmp_wr = 1'b0;
        begin
            int c2;
            high_count(255, c2);
            c += c2;
        end
        produce(c);
        expect_val("R9 coincident write loaded later", 51);
        high_count(256, c);
        produce(c);

        // R10: pin source switches at once with the unbuffered mode field
        duty_check("R10 setup v=255", 1'b0, 2'b10, 255, 256);
        out_mode = 2'b00;
        port_val = 1'b0;
        #1;
        expect_val("R10 port path low", 0);
        produce(int'(pwm_pin));
        port_val = 1'b1;
        #1;
        expect_val("R10 port path high", 1);
        produce(int'(pwm_pin));
        port_val = 1'b0;
        out_mode = 2'b01;
        #1;
        expect_val("R10 hold mode shows stored state", 1);
        produce(int'(pwm_pin));
        duty_check("R10 hold mode ignores matches", 1'b0, 2'b01, 0, 256);

        // R11: no tick, no movement
        duty_check("R11 setup fast v=0", 1'b0, 2'b10, 0, 1);
        @(negedge clk);
        tick_sel = 0;
        wait_n(2);
        expect_val("R11 no overflow without tick", 0);
        ovf_count(600, c);
        produce(c);
        // R11: half-rate ticks double the duty in clocks
        tick_sel = 2;
        set_cfg(1'b0, 2'b10, 50);
        wait_n(1300);
        expect_val("R11 half-rate duty", 102);
        high_count(512, c);
        produce(c);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule